// File: doc/BRIEF.md
# Sparse Pixel-Array Readout Scanner

This controller empties a square array of hit-recording pixels during the gap between particle bunch trains, when no new hits can arrive. It sees one "empty" flag per pixel. It selects one pixel and one stamp slot at a time through a row/column multiplexer, and turns the pixels that hold data into a stream of words. Each word carries the pixel's row and column, the slot index and the stored timestamp. Pixels with no hits cost no readout time. A two-level priority search, first over rows and then over columns, finds the next occupied pixel within the same cycle in which the previous pixel's last word is accepted.

A readout starts with a one-cycle start strobe. The output stream follows valid/ready handshaking, and the scan halts while the consumer holds ready low. After the final word of a pixel is accepted, the scanner pulses a clear strobe carrying that pixel's address so that the array can reset the pixel. When no occupied pixel is left, a done flag is raised. It stays raised until the next start. The whole scan has to finish before the next bunch train, so the scan time depends only on the number of stored stamps and on consumer stalls, not on the array size.

Top module: `sparse_readout_scanner`

## Requirements
- R1: While reset is active and after it is released, out_valid, clr_stb and done are low until the first start.
- R2: A start strobe seen while the scanner is idle or done begins a scan from pixel (0,0). A start strobe seen while words are still being streamed has no effect on the stream.
- R3: Only pixels whose pix_empty bit (index row*DIM+col, 1 = empty) is low are emitted. They come in row-major order: ascending row, then ascending column within a row.
- R4: For a pixel with pix_cnt stamps, words with out_idx 0 up to pix_cnt-1 are emitted in that order. out_stamp equals pix_stamp for the selected row, column and index. out_last is 1 only on the word with index pix_cnt-1.
- R5: With out_ready held high, the first word is valid in the cycle after start is sampled. Each later word follows in the very next cycle, so a scan of N words ends with done after exactly N+1 cycles.
- R6: While out_valid is high and out_ready is low, the word and its address hold unchanged.
- R7: One cycle after a pixel's last word is accepted, clr_stb is high for one cycle with clr_row/clr_col set to that pixel.
- R8: done rises in the cycle after the final word is accepted, or one cycle after start if no pixel is occupied. It then stays high until the next start, and out_valid is low while done is high.
- R9: The array dimension DIM is a parameter, and the corner pixels (0,0) and (DIM-1,DIM-1) are read like any other pixel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start-of-readout strobe |
| pix_empty | input | DIM*DIM | Per-pixel empty flags, bit row*DIM+col |
| sel_row | output | $clog2(DIM) | Multiplexer row select |
| sel_col | output | $clog2(DIM) | Multiplexer column select |
| sel_idx | output | IXW | Multiplexer stamp-slot select |
| pix_cnt | input | $clog2(DEPTH+1) | Stamp count of the selected pixel |
| pix_stamp | input | TS_W | Stamp of the selected pixel and slot |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Consumer ready |
| out_row | output | $clog2(DIM) | Row of the word |
| out_col | output | $clog2(DIM) | Column of the word |
| out_idx | output | IXW | Stamp slot of the word |
| out_stamp | output | TS_W | Timestamp |
| out_last | output | 1 | Final word of this pixel |
| clr_stb | output | 1 | Pixel clear strobe |
| clr_row | output | $clog2(DIM) | Row to clear |
| clr_col | output | $clog2(DIM) | Column to clear |
| done | output | 1 | No occupied pixel remains |

## Verification
The scan is driven with four array patterns: no hits at all, hits only in the two corner pixels, a sparse random fill, and a dense random fill with one- and two-stamp pixels mixed. The empty array and the corner-only array show whether the search wraps and ends correctly at both ends of the address space. The sparse and dense fills show whether rows with no hits and runs of adjacent occupied pixels are handled without bubbles. Each pattern is run with ready held high, with ready alternating and with ready random, which separates the zero-gap timing from the hold-under-stall behaviour. One run also pulses start in the middle of a scan to show that the stray strobe is ignored.

// File: rtl/pscan_pkg.sv
package pscan_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_EMIT = 2'd1,
    ST_DONE = 2'd2
  } scan_st_e;
endpackage

// File: rtl/pscan_rst_sync.sv
module pscan_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/pscan_first.sv
// Lowest-index set bit finder.
module pscan_first #(
  parameter  int N  = 8,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  vec,
  output logic          found,
  output logic [IW-1:0] pos
);
  always_comb begin
    found = |vec;
    pos   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) pos = IW'(i);
    end
  end
endmodule

// File: rtl/pscan_search.sv
// Two-level search: first occupied pixel at or after (from_row, from_col).
module pscan_search #(
  parameter  int DIM = 8,
  localparam int RW  = (DIM > 1) ? $clog2(DIM) : 1
) (
  input  logic [DIM*DIM-1:0] occ,
  input  logic               from_ok,
  input  logic [RW-1:0]      from_row,
  input  logic [RW-1:0]      from_col,
  output logic               hit,
  output logic [RW-1:0]      hit_row,
  output logic [RW-1:0]      hit_col
);
  logic [DIM-1:0] col_mask;
  logic [DIM-1:0] row_any;
  logic [DIM-1:0] row_bits;
  logic [DIM-1:0] col_vec;
  logic           col_found;

  for (genvar c = 0; c < DIM; c++) begin : g_mask
    assign col_mask[c] = (RW'(c) >= from_col);
  end

  for (genvar r = 0; r < DIM; r++) begin : g_rows
    logic [DIM-1:0] bits;
    assign bits = occ[r*DIM +: DIM];
    always_comb begin
      if (!from_ok)                  row_any[r] = 1'b0;
      else if (RW'(r) > from_row)    row_any[r] = |bits;
      else if (RW'(r) == from_row)   row_any[r] = |(bits & col_mask);
      else                           row_any[r] = 1'b0;
    end
  end

  pscan_first #(.N(DIM)) u_row_pick (
    .vec   (row_any),
    .found (hit),
    .pos   (hit_row)
  );

  always_comb begin
    row_bits = occ[int'(hit_row)*DIM +: DIM];
    col_vec  = (hit_row == from_row) ? (row_bits & col_mask) : row_bits;
  end

  pscan_first #(.N(DIM)) u_col_pick (
    .vec   (col_vec),
    .found (col_found),
    .pos   (hit_col)
  );

  logic unused_ok;
  assign unused_ok = col_found;
endmodule

// File: rtl/sparse_readout_scanner.sv
module sparse_readout_scanner
  import pscan_pkg::*;
#(
  parameter  int DIM   = 8,
  parameter  int DEPTH = 2,
  parameter  int TS_W  = 14,
  localparam int RW    = (DIM > 1) ? $clog2(DIM) : 1,
  localparam int IXW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [DIM*DIM-1:0] pix_empty,
  output logic [RW-1:0]      sel_row,
  output logic [RW-1:0]      sel_col,
  output logic [IXW-1:0]     sel_idx,
  input  logic [CNT_W-1:0]   pix_cnt,
  input  logic [TS_W-1:0]    pix_stamp,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [RW-1:0]      out_row,
  output logic [RW-1:0]      out_col,
  output logic [IXW-1:0]     out_idx,
  output logic [TS_W-1:0]    out_stamp,
  output logic               out_last,
  output logic               clr_stb,
  output logic [RW-1:0]      clr_row,
  output logic [RW-1:0]      clr_col,
  output logic               done
);
  logic rst_q_n;

  pscan_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_q_n));

  scan_st_e       state_q, state_d;
  logic [RW-1:0]  row_q, col_q, row_d, col_d;
  logic [IXW-1:0] idx_q, idx_d;
  logic           pix_en, idx_en;
  logic           clr_d;

  logic [RW-1:0]  from_row, from_col;
  logic           from_ok;
  logic           hit;
  logic [RW-1:0]  hit_row, hit_col;
  logic           fire, last_w;

  // search starts one past the current pixel while streaming, else at (0,0)
  always_comb begin
    from_ok  = 1'b1;
    from_row = '0;
    from_col = '0;
    if (state_q == ST_EMIT) begin
      from_ok = !((row_q == RW'(DIM - 1)) && (col_q == RW'(DIM - 1)));
      if (col_q == RW'(DIM - 1)) begin
        from_row = row_q + 1'b1;
        from_col = '0;
      end else begin
        from_row = row_q;
        from_col = col_q + 1'b1;
      end
    end
  end

  pscan_search #(.DIM(DIM)) u_search (
    .occ      (~pix_empty),
    .from_ok  (from_ok),
    .from_row (from_row),
    .from_col (from_col),
    .hit      (hit),
    .hit_row  (hit_row),
    .hit_col  (hit_col)
  );

  assign out_valid = (state_q == ST_EMIT);
  assign fire      = out_valid && out_ready;
  assign last_w    = (int'(idx_q) + 1) >= int'(pix_cnt);

  // next state
  always_comb begin
    state_d = state_q;
    row_d   = row_q;
    col_d   = col_q;
    idx_d   = idx_q;
    pix_en  = 1'b0;
    idx_en  = 1'b0;
    clr_d   = 1'b0;
    case (state_q)
      ST_IDLE, ST_DONE: begin
        if (start) begin
          if (hit) begin
            state_d = ST_EMIT;
            pix_en  = 1'b1;
            row_d   = hit_row;
            col_d   = hit_col;
            idx_en  = 1'b1;
            idx_d   = '0;
          end else begin
            state_d = ST_DONE;
          end
        end
      end
      ST_EMIT: begin
        if (fire) begin
          idx_en = 1'b1;
          if (!last_w) begin
            idx_d = idx_q + 1'b1;
          end else begin
            clr_d = 1'b1;
            idx_d = '0;
            if (hit) begin
              pix_en = 1'b1;
              row_d  = hit_row;
              col_d  = hit_col;
            end else begin
              state_d = ST_DONE;
            end
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      state_q <= ST_IDLE;
      row_q   <= '0;
      col_q   <= '0;
      idx_q   <= '0;
      clr_stb <= 1'b0;
      clr_row <= '0;
      clr_col <= '0;
    end else begin
      state_q <= state_d;
      if (pix_en) begin
        row_q <= row_d;
        col_q <= col_d;
      end
      if (idx_en) idx_q <= idx_d;
      clr_stb <= clr_d;
      if (clr_d) begin
        clr_row <= row_q;
        clr_col <= col_q;
      end
    end
  end

  assign sel_row   = row_q;
  assign sel_col   = col_q;
  assign sel_idx   = idx_q;
  assign out_row   = row_q;
  assign out_col   = col_q;
  assign out_idx   = idx_q;
  assign out_stamp = pix_stamp;
  assign out_last  = last_w;
  assign done      = (state_q == ST_DONE);

  AST_HOLD_ON_STALL: assert property (@(posedge clk) disable iff (!rst_q_n)
    out_valid && !out_ready |=> out_valid && $stable(out_row) && $stable(out_col) && $stable(out_idx)); // R6

  AST_CLR_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_q_n)
    out_valid && out_ready && out_last |=> clr_stb && clr_row == $past(out_row) && clr_col == $past(out_col)); // R7

  AST_SEL_OCCUPIED: assert property (@(posedge clk) disable iff (!rst_q_n)
    out_valid |-> !pix_empty[int'(out_row)*DIM + int'(out_col)]); // R3

  AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rst_q_n)
    out_valid && out_ready && !out_last |=> out_valid && out_idx == $past(out_idx) + 1'b1 && $stable(out_row) && $stable(out_col)); // R4

  AST_NEW_PIXEL_SLOT0: assert property (@(posedge clk) disable iff (!rst_q_n)
    $rose(out_valid) |-> out_idx == '0); // R4

  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_q_n)
    done && !start |=> done && !out_valid); // R8

  AST_ORDER_FWD: assert property (@(posedge clk) disable iff (!rst_q_n)
    out_valid && out_ready && out_last |=> !out_valid || out_row > $past(out_row) ||
      (out_row == $past(out_row) && out_col > $past(out_col))); // R3
endmodule

// File: tb/test_sparse_readout_scanner.sv
module test_sparse_readout_scanner;
  localparam int DIM   = 8;
  localparam int DEPTH = 2;
  localparam int TS_W  = 14;
  localparam int RW    = $clog2(DIM);
  localparam int IXW   = 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int NPIX  = DIM * DIM;

  logic clk, rst_n, start, out_ready;
  logic [NPIX-1:0]   pix_empty;
  logic [RW-1:0]     sel_row, sel_col, out_row, out_col, clr_row, clr_col;
  logic [IXW-1:0]    sel_idx, out_idx;
  logic [CNT_W-1:0]  pix_cnt;
  logic [TS_W-1:0]   pix_stamp, out_stamp;
  logic              out_valid, out_last, clr_stb, done;

  sparse_readout_scanner #(.DIM(DIM), .DEPTH(DEPTH), .TS_W(TS_W)) i_sparse_readout_scanner (
    .clk(clk), .rst_n(rst_n), .start(start), .pix_empty(pix_empty),
    .sel_row(sel_row), .sel_col(sel_col), .sel_idx(sel_idx),
    .pix_cnt(pix_cnt), .pix_stamp(pix_stamp),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_row(out_row), .out_col(out_col), .out_idx(out_idx),
    .out_stamp(out_stamp), .out_last(out_last),
    .clr_stb(clr_stb), .clr_row(clr_row), .clr_col(clr_col), .done(done)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // behavioural pixel array
  bit       emp [NPIX];
  int       cnt_a [NPIX];
  int       st_a [NPIX][DEPTH];

  always_comb begin
    for (int i = 0; i < NPIX; i++) pix_empty[i] = emp[i];
  end
  always_comb begin
    pix_cnt   = CNT_W'(cnt_a[int'(sel_row)*DIM + int'(sel_col)]);
    pix_stamp = TS_W'(st_a[int'(sel_row)*DIM + int'(sel_col)][int'(sel_idx)]);
  end
  always @(posedge clk) begin
    if (clr_stb) emp[int'(clr_row)*DIM + int'(clr_col)] <= 1'b1;
  end

  int n_chk = 0;
  int n_err = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // reference model
  typedef struct { int r; int c; int ix; int st; bit last; } wd_t;
  wd_t q[$];
  bit  mon_on = 0;
  bit  done_m = 0;
  bit  clr_m  = 0;
  int  clr_r_m, clr_c_m;
  bit  stalled = 0;

  always @(negedge clk) begin
    if (mon_on) begin
      bit  exp_v, fire;
      string tg;
      exp_v = (q.size() > 0);
      chk(out_valid == exp_v, "R5", out_valid, exp_v);
      if (exp_v && out_valid) begin
        tg = stalled ? "R6" : "R3";
        chk(int'(out_row) == q[0].r, tg, out_row, q[0].r);
        chk(int'(out_col) == q[0].c, tg, out_col, q[0].c);
        chk(int'(out_idx) == q[0].ix, "R4", out_idx, q[0].ix);
        chk(int'(out_stamp) == q[0].st, "R4", out_stamp, q[0].st);
        chk(out_last == q[0].last, "R4", out_last, q[0].last);
      end
      chk(done == done_m, "R8", done, done_m);
      if (done) chk(!out_valid, "R8", out_valid, 0);
      chk(clr_stb == clr_m, "R7", clr_stb, clr_m);
      if (clr_m && clr_stb) begin
        chk(int'(clr_row) == clr_r_m, "R7", clr_row, clr_r_m);
        chk(int'(clr_col) == clr_c_m, "R7", clr_col, clr_c_m);
      end
      // predict the state after the coming edge
      fire    = exp_v && out_ready;
      stalled = exp_v && !out_ready;
      clr_m   = 1'b0;
      if (fire) begin
        if (q[0].last) begin
          clr_m   = 1'b1;
          clr_r_m = q[0].r;
          clr_c_m = q[0].c;
        end
        void'(q.pop_front());
        if (q.size() == 0) done_m = 1'b1;
      end
      if (start && !exp_v) begin
        for (int p = 0; p < NPIX; p++) begin
          if (!emp[p]) begin
            for (int k = 0; k < cnt_a[p]; k++) begin
              wd_t w;
              w.r = p / DIM; w.c = p % DIM; w.ix = k; w.st = st_a[p][k];
              w.last = (k == cnt_a[p] - 1);
              q.push_back(w);
            end
          end
        end
        done_m = (q.size() == 0);
      end
    end
  end

  task automatic clear_array();
    for (int p = 0; p < NPIX; p++) begin
      emp[p] = 1'b1; cnt_a[p] = 0;
      for (int k = 0; k < DEPTH; k++) st_a[p][k] = 0;
    end
  endtask

  task automatic set_pix(input int r, input int c, input int n);
    emp[r*DIM + c]   = 1'b0;
    cnt_a[r*DIM + c] = n;
    for (int k = 0; k < DEPTH; k++) st_a[r*DIM + c][k] = int'($urandom_range(0, (1 << TS_W) - 1));
  endtask

  task automatic fill_random(input int pct);
    clear_array();
    for (int p = 0; p < NPIX; p++) begin
      if (int'($urandom_range(0, 99)) < pct) set_pix(p / DIM, p % DIM, int'($urandom_range(1, DEPTH)));
    end
  endtask

  function automatic int words_in_array();
    int n = 0;
    for (int p = 0; p < NPIX; p++) if (!emp[p]) n += cnt_a[p];
    return n;
  endfunction

  // mode: 0 ready high, 1 alternating, 2 random, 3 random with mid-scan start
  task automatic run_scan(input int mode, input string tag);
    int nw, cyc, left;
    nw = words_in_array();
    @(posedge clk); #1;
    start = 1'b1; out_ready = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    cyc = 0;
    while (1) begin
      @(negedge clk);
      cyc++;
      if (done) break;
      if (cyc > 5000) break;
      @(posedge clk); #1;
      case (mode)
        0: out_ready = 1'b1;
        1: out_ready = ~out_ready;
        default: out_ready = 1'($urandom_range(0, 1));
      endcase
      start = (mode == 3 && cyc == 3);
    end
    start = 1'b0;
    if (mode == 0) chk(cyc == nw + 1, "R5", cyc, nw + 1);
    chk(done == 1'b1, "R8", done, 1);
    repeat (3) @(posedge clk);
    #1 out_ready = 1'b1;
    left = 0;
    for (int p = 0; p < NPIX; p++) if (!emp[p]) left++;
    chk(left == 0, tag, left, 0);
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; out_ready = 1'b0;
    clear_array();
    repeat (3) @(posedge clk);
    #1;
    chk(out_valid == 1'b0, "R1", out_valid, 0);
    chk(done == 1'b0, "R1", done, 0);
    chk(clr_stb == 1'b0, "R1", clr_stb, 0);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(out_valid == 1'b0, "R1", out_valid, 0);
    chk(done == 1'b0, "R1", done, 0);
    chk(clr_stb == 1'b0, "R1", clr_stb, 0);
    mon_on = 1'b1;

    // empty array: done one cycle after start (R8)
    run_scan(0, "R8");
    // corners only (R9)
    clear_array();
    set_pix(0, 0, 2);
    set_pix(DIM - 1, DIM - 1, 1);
    run_scan(0, "R9");
    set_pix(0, 0, 1);
    set_pix(DIM - 1, DIM - 1, 2);
    run_scan(1, "R9");
    // sparse and dense fills under each ready pattern (R3 R4 R5 R6 R7)
    for (int m = 0; m < 3; m++) begin
      fill_random(5);
      run_scan(m, "R7");
      fill_random(70);
      run_scan(m, "R7");
    end
    // full array, ready high
    clear_array();
    for (int p = 0; p < NPIX; p++) set_pix(p / DIM, p % DIM, 1 + (p % 2));
    run_scan(0, "R3");
    // start pulse during a scan is ignored (R2)
    fill_random(50);
    run_scan(3, "R2");

    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule